// File: doc/BRIEF.md
# Cascaded Divider Pair Search Engine

This block takes a requested overall divide ratio and chooses settings for a two-stage cascaded clock divider. The first stage is a prescaler with a value from 1 to 8. The second stage is a postscaler with a value from 1 to 64. The engine looks for the pair whose product comes closest to the request. Each value is returned twice: once as a plain value and once as a field code (value minus one) that can be loaded straight into the divider's control bits.

Small and very large ratios are resolved by fixed shortcuts. A ratio that fits inside one stage goes to that stage alone, and a ratio beyond the reach of both stages is clamped to the largest pair. Middle ratios are solved by a sequential search. The search tests one prescaler candidate per clock, starting from the largest and counting down, and a restoring modulo unit computes each remainder. Once a prescaler is chosen, a second restoring divider works out the rounded-up postscaler.

Control is a plain start/busy/done handshake. The ratio is taken on the clock edge where `start_i` is high and the engine is idle. The engine has no data stream and applies no back-pressure. A start that arrives while the engine is busy is dropped and is not queued, so the caller must wait for `done_o` before it issues a new request.

Top module: `divpair_search`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0, `pre_o` and `post_o` are both 1, and both field outputs are 0.
- R2: A requested ratio of 0 is handled exactly like a ratio of 1, giving prescaler 1 and postscaler 1.
- R3: A ratio from 1 to 8 gives a prescaler equal to the ratio and a postscaler of 1. `done_o` rises on the clock edge that accepts the start.
- R4: A ratio from 9 to 63 gives a prescaler of 1 and a postscaler equal to the ratio. `done_o` rises on the accepting edge.
- R5: A ratio of 512 or more gives prescaler 8 and postscaler 64 and runs no search.
- R6: For a ratio r from 64 to 511, candidates are tried from 8 down to ceil(r/64).
  - The first candidate that divides r exactly is chosen, and the search stops there.
  - Otherwise the choice starts with an error bound of 8. A candidate c replaces the current choice only when c minus (r mod c) is strictly below the best error so far.
- R7: In the search range the postscaler equals ceil(r / prescaler).
- R8: `pre_fld_o` equals `pre_o` minus one and `post_fld_o` equals `post_o` minus one, as unsigned binary.
- R9: `done_o` is high for exactly one cycle per accepted request. The results stay unchanged until the next accepted start.
- R10: A start request while `busy_o` is high is ignored. The running search finishes with the ratio it accepted first, and no extra `done_o` pulse follows.
- R11: `busy_o` is high from the cycle after a search-range start is accepted until the cycle in which `done_o` is high, and it is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a new search (taken only when idle) |
| ratio_i | input | 16 | Requested total divide ratio |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result strobe |
| pre_o | output | 4 | Chosen prescaler value, 1 to 8 |
| post_o | output | 7 | Chosen postscaler value, 1 to 64 |
| pre_fld_o | output | 3 | Prescaler field code (value minus one) |
| post_fld_o | output | 6 | Postscaler field code (value minus one) |

## Verification
The bench aims at the shortcut boundaries 0, 8, 9, 63, 64, 511 and 512, and at the largest input value. An off-by-one in any range test would send one of these ratios down the wrong path and return a swapped or unsearched pair. In the search range it uses ratios where a later candidate has the same error as an earlier one, such as 127. A design that replaced the choice on a tie would pick a smaller prescaler and a larger postscaler. It also uses ratios where an exact divisor sits below an inexact candidate with a small error, such as 100, and a design that skipped the early exit would miss that divisor. Repeated start pulses during a search check that a design which latched them would neither return the wrong pair nor signal completion twice.

// File: rtl/divpair_pkg.sv
package divpair_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_POST = 2'd2
  } divpair_st_e;
endpackage

// File: rtl/divpair_div.sv
module divpair_div #(
  parameter int NUM_W = 9,
  parameter int DEN_W = 4
) (
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quot_o,
  output logic [DEN_W-1:0] rem_o
);
  logic [DEN_W:0] acc;
  logic [DEN_W:0] trial;

  // restoring division, one quotient bit per unrolled step
  always_comb begin
    acc    = '0;
    trial  = '0;
    quot_o = '0;
    for (int b = NUM_W - 1; b >= 0; b--) begin
      trial = {acc[DEN_W-1:0], num_i[b]};
      if (trial >= {1'b0, den_i}) begin
        acc       = trial - {1'b0, den_i};
        quot_o[b] = 1'b1;
      end else begin
        acc = trial;
      end
    end
    rem_o = acc[DEN_W-1:0];
  end
endmodule

// File: rtl/divpair_ctrl.sv
module divpair_ctrl
  import divpair_pkg::*;
#(
  parameter int RAT_W    = 16,
  parameter int PRE_MAX  = 8,
  parameter int POST_MAX = 64,
  localparam int SAT     = PRE_MAX * POST_MAX,
  localparam int SCAN_W  = $clog2(SAT),
  localparam int PRE_W   = $clog2(PRE_MAX + 1),
  localparam int POST_W  = $clog2(POST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [RAT_W-1:0]  ratio_i,
  input  logic [PRE_W-1:0]  rem_i,
  input  logic [POST_W-1:0] quot_i,
  output logic [SCAN_W-1:0] ratio_lo_o,
  output logic [PRE_W-1:0]  cand_o,
  output logic [PRE_W-1:0]  best_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [PRE_W-1:0]  pre_o,
  output logic [POST_W-1:0] post_o
);
  divpair_st_e       st;
  logic [RAT_W-1:0]  ratio_q;
  logic [RAT_W-1:0]  rn;
  logic [PRE_W-1:0]  cand, best, err, minp;
  logic [PRE_W-1:0]  cerr;
  logic [SCAN_W:0]   minp_sum;
  logic [SCAN_W:0]   minp_div;

  assign rn       = (ratio_i == '0) ? RAT_W'(1) : ratio_i;
  assign minp_sum = {1'b0, rn[SCAN_W-1:0]} + (SCAN_W+1)'(POST_MAX - 1);
  assign minp_div = minp_sum / (SCAN_W+1)'(POST_MAX);
  assign cerr     = cand - rem_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ratio_q <= RAT_W'(1);
      cand    <= PRE_W'(PRE_MAX);
      best    <= PRE_W'(PRE_MAX);
      err     <= PRE_W'(PRE_MAX);
      minp    <= PRE_W'(1);
      pre_o   <= PRE_W'(1);
      post_o  <= POST_W'(1);
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        ST_IDLE: if (start_i) begin
          ratio_q <= rn;
          if (rn >= RAT_W'(SAT)) begin
            pre_o  <= PRE_W'(PRE_MAX);
            post_o <= POST_W'(POST_MAX);
            done_o <= 1'b1;
          end else if (rn <= RAT_W'(PRE_MAX)) begin
            pre_o  <= PRE_W'(rn);
            post_o <= POST_W'(1);
            done_o <= 1'b1;
          end else if (rn < RAT_W'(POST_MAX)) begin
            pre_o  <= PRE_W'(1);
            post_o <= POST_W'(rn);
            done_o <= 1'b1;
          end else begin
            cand <= PRE_W'(PRE_MAX);
            best <= PRE_W'(PRE_MAX);
            err  <= PRE_W'(PRE_MAX);
            minp <= PRE_W'(minp_div);
            st   <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (rem_i == '0) begin
            best <= cand;
            st   <= ST_POST;
          end else begin
            if (cerr < err) begin
              err  <= cerr;
              best <= cand;
            end
            if (cand == minp) st <= ST_POST;
            else              cand <= cand - PRE_W'(1);
          end
        end
        ST_POST: begin
          pre_o  <= best;
          post_o <= quot_i;
          done_o <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st != ST_IDLE);
  assign ratio_lo_o = ratio_q[SCAN_W-1:0];
  assign cand_o     = cand;
  assign best_o     = best;

  assert_cand_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SCAN) |-> (cand >= minp && cand <= PRE_W'(PRE_MAX) && minp >= PRE_W'(1)));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !done_o);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(pre_o) && $stable(post_o)));
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(ratio_q));
  assert_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ratio_q >= RAT_W'(SAT)) |-> (pre_o == PRE_W'(PRE_MAX) && post_o == POST_W'(POST_MAX)));
  assert_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ratio_q < RAT_W'(SAT)) |-> ((RAT_W'(pre_o) * RAT_W'(post_o)) >= ratio_q));
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: rtl/divpair_search.sv
module divpair_search #(
  parameter int RAT_W    = 16,
  parameter int PRE_MAX  = 8,
  parameter int POST_MAX = 64,
  localparam int SAT     = PRE_MAX * POST_MAX,
  localparam int SCAN_W  = $clog2(SAT),
  localparam int PRE_W   = $clog2(PRE_MAX + 1),
  localparam int POST_W  = $clog2(POST_MAX + 1),
  localparam int PRE_FW  = $clog2(PRE_MAX),
  localparam int POST_FW = $clog2(POST_MAX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [RAT_W-1:0]   ratio_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [PRE_W-1:0]   pre_o,
  output logic [POST_W-1:0]  post_o,
  output logic [PRE_FW-1:0]  pre_fld_o,
  output logic [POST_FW-1:0] post_fld_o
);
  logic [SCAN_W-1:0] ratio_lo;
  logic [PRE_W-1:0]  cand, best, rem;
  logic [SCAN_W-1:0] mod_quot;
  logic [SCAN_W:0]   up_num, up_quot;
  logic [PRE_W-1:0]  up_rem;

  divpair_ctrl #(.RAT_W(RAT_W), .PRE_MAX(PRE_MAX), .POST_MAX(POST_MAX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ratio_i(ratio_i),
    .rem_i(rem), .quot_i(up_quot[POST_W-1:0]),
    .ratio_lo_o(ratio_lo), .cand_o(cand), .best_o(best),
    .busy_o(busy_o), .done_o(done_o), .pre_o(pre_o), .post_o(post_o)
  );

  // remainder of the ratio by the current candidate
  divpair_div #(.NUM_W(SCAN_W), .DEN_W(PRE_W)) u_mod (
    .num_i(ratio_lo), .den_i(cand), .quot_o(mod_quot), .rem_o(rem)
  );

  // rounded-up postscaler for the chosen prescaler
  assign up_num = {1'b0, ratio_lo} + (SCAN_W+1)'(best) - (SCAN_W+1)'(1);
  divpair_div #(.NUM_W(SCAN_W+1), .DEN_W(PRE_W)) u_post (
    .num_i(up_num), .den_i(best), .quot_o(up_quot), .rem_o(up_rem)
  );

  assign pre_fld_o  = PRE_FW'(pre_o - PRE_W'(1));
  assign post_fld_o = POST_FW'(post_o - POST_W'(1));

  assert_ranges_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pre_o >= PRE_W'(1) && pre_o <= PRE_W'(PRE_MAX) &&
                post_o >= POST_W'(1) && post_o <= POST_W'(POST_MAX)));
endmodule

// File: tb/divpair_search_tb.sv
module divpair_search_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] ratio_i = '0;
  logic        busy_o, done_o;
  logic [3:0]  pre_o;
  logic [6:0]  post_o;
  logic [2:0]  pre_fld_o;
  logic [5:0]  post_fld_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  divpair_search u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ratio_i(ratio_i),
    .busy_o(busy_o), .done_o(done_o), .pre_o(pre_o), .post_o(post_o),
    .pre_fld_o(pre_fld_o), .post_fld_o(post_fld_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void ref_pair(input int r, output int p, output int q);
    int rr, minp, err, m;
    rr = (r == 0) ? 1 : r;
    if (rr >= 512) begin p = 8; q = 64; end
    else if (rr <= 8) begin p = rr; q = 1; end
    else if (rr < 64) begin p = 1; q = rr; end
    else begin
      minp = (rr + 63) / 64;
      p = 8; err = 8;
      for (int c = 8; c >= minp; c--) begin
        m = rr % c;
        if (m == 0) begin p = c; break; end
        if (c - m < err) begin err = c - m; p = c; end
      end
      q = (rr + p - 1) / p;
    end
  endfunction

  function automatic string tag_for(input int r);
    if (r == 0) return "R2";
    if (r <= 8) return "R3";
    if (r < 64) return "R4";
    if (r >= 512) return "R5";
    return "R6";
  endfunction

  task automatic run_one(input int r, input bit interfere);
    int ep, eq;
    bit got;
    bit srch;
    string t;
    srch = (r >= 64 && r < 512);
    t = tag_for(r);
    ref_pair(r, ep, eq);
    @(negedge clk);
    start_i = 1'b1;
    ratio_i = 16'(r);
    @(negedge clk);
    start_i = 1'b0;
    if (srch) chk(busy_o == 1'b1, "R11 busy after start", int'(busy_o), 1);
    if (interfere && srch) begin
      start_i = 1'b1;
      ratio_i = 16'(r ^ 16'h0155);
      @(negedge clk);
      start_i = 1'b0;
    end
    got = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done_o) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk(got, "R9 done seen", int'(got), 1);
    chk(int'(pre_o) == ep, interfere ? "R10 pre" : {t, " pre"}, int'(pre_o), ep);
    chk(int'(post_o) == eq, srch ? (interfere ? "R10 post" : "R7 post") : {t, " post"}, int'(post_o), eq);
    chk(int'(pre_fld_o) == ep - 1, "R8 pre field", int'(pre_fld_o), ep - 1);
    chk(int'(post_fld_o) == eq - 1, "R8 post field", int'(post_fld_o), eq - 1);
    chk(busy_o == 1'b0, "R11 idle at done", int'(busy_o), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(done_o == 1'b0, interfere ? "R10 no extra done" : "R9 single pulse", int'(done_o), 0);
      chk(int'(pre_o) == ep && int'(post_o) == eq, "R9 hold", int'(pre_o) * 100 + int'(post_o), ep * 100 + eq);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int sel, r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 reset flags", int'(busy_o) + int'(done_o), 0);
    chk(pre_o == 4'd1 && post_o == 7'd1, "R1 reset values", int'(pre_o) * 100 + int'(post_o), 101);
    chk(pre_fld_o == 3'd0 && post_fld_o == 6'd0, "R1 reset fields", int'(pre_fld_o) + int'(post_fld_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_one(0, 1'b0);
    run_one(1, 1'b0);
    run_one(8, 1'b0);
    run_one(9, 1'b0);
    run_one(63, 1'b0);
    run_one(64, 1'b0);
    run_one(65, 1'b0);
    run_one(100, 1'b0);
    run_one(127, 1'b0);
    run_one(200, 1'b0);
    run_one(511, 1'b0);
    run_one(512, 1'b0);
    run_one(65535, 1'b0);
    run_one(127, 1'b1);
    run_one(333, 1'b1);

    for (int n = 0; n < 200; n++) begin
      sel = int'($urandom % 8);
      case (sel)
        0: r = int'($urandom % 9);
        1: r = 9 + int'($urandom % 55);
        2: r = 512 + int'($urandom % 65024);
        default: r = 64 + int'($urandom % 448);
      endcase
      run_one(r, (n % 5) == 0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule